// File: doc/BRIEF.md
# Two-Channel Digital LO Mixer with Zero-Stuffing

This block is the mixing stage of a two-channel transmit datapath. It runs on the output-rate clock and takes one signed 12-bit sample per channel, with a valid strobe. An interpolating stage upstream delivers these samples at a half, a quarter or an eighth of that rate. Each channel multiplies its sample stream by a local oscillator at half, a quarter or an eighth of the output rate, or passes it through unmixed.

An optional zero-stuffing stage puts zeros in place of the missing samples before the mixing. This flattens the droop that the converter's hold response puts on the pass band. In coupled mode the two channels form one complex modulator. Channel A carries the in-phase input and channel B the quadrature input, and the outputs are the cosine-and-sine combinations that an external quadrature modulator needs.

The oscillator only takes eight phase positions, so it is built from short fixed coefficient sequences and not from a numerically controlled oscillator. A shared 3-bit phase counter steps once per output cycle. It restarts at zero on reset and on any change of the configuration, so every output sequence can be predicted from the configuration and the inputs alone.

Top module: `lo_mixer`

## Requirements
- R1: After reset both outputs are 0.
- R2: With `lo_sel_i` = 0 (no mixing) and `couple_i` = 0, each output equals its channel's stuffed sample.
- R3: With `lo_sel_i` = 1 (half rate) the cosine coefficient is +1 on even phases and -1 on odd phases. The sine coefficient is 0. A result of +2048 saturates to +2047.
- R4: With `lo_sel_i` = 2 (quarter rate) the cosine over phase mod 4 is 1, 0, -1, 0 and the sine is 0, 1, 0, -1.
- R5: With `lo_sel_i` = 3 (eighth rate) the cosine over phases 0 to 7 is 1, c, 0, -c, -1, -c, 0, c and the sine is 0, c, 1, c, 0, -c, -1, -c. Here c·x means (x·23170 + 16384) >>> 15, and -c·x is the negation of that value.
- R6: A cycle with `valid_i` high carries the input sample into the stream. In a cycle with `valid_i` low, the stream carries 0 when `zstuff_i` = 1 and repeats the last valid sample when `zstuff_i` = 0. Mixing is applied after this stage.
- R7: With `couple_i` = 1, A = I·cos − Q·sin and B = I·sin + Q·cos, with I the stuffed A stream and Q the stuffed B stream. Each term is rounded on its own, and each sum saturates to [-2048, 2047].
- R8: The phase is 0 for the sample that enters in a cycle where {`lo_sel_i`, `zstuff_i`, `couple_i`} differs from the previous cycle, and for the first sample after reset. Otherwise the phase advances by 1 mod 8 every clock cycle.
- R9: An input sampled at clock edge k appears on the outputs after edge k+1. The latency is two registers.
- R10: With `couple_i` = 0 each channel mixes only its own data. Both channels use the shared phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input samples present this cycle |
| a_i | input | 12 | Channel A / I sample, signed |
| b_i | input | 12 | Channel B / Q sample, signed |
| lo_sel_i | input | 2 | 0 none, 1 half, 2 quarter, 3 eighth of output rate |
| zstuff_i | input | 1 | Zero-stuff enable |
| couple_i | input | 1 | Complex I/Q coupling enable |
| a_o | output | 12 | Channel A output, signed |
| b_o | output | 12 | Channel B output, signed |

## Verification
A configuration change and a stuffed zero slot can land in the same cycle. The phase then restarts on a sample that is already forced to zero, and the next real sample must pick up phase 1, not phase 0. The bench provokes this by switching the oscillator rate and the coupling on the idle cycles of an alternating valid pattern with zero-stuffing on. A scoreboard model then judges every output. That model tracks the previous configuration, the phase and the held samples from the requirement text. The same runs drive full-scale inputs in coupled eighth-rate mode, so that rounding and saturation coincide with the phase restart.

// File: rtl/lo_mixer_pkg.sv
package lo_mixer_pkg;

  localparam int unsigned PH_W = 3;

  typedef enum logic [1:0] {
    LO_NONE    = 2'd0,
    LO_HALF    = 2'd1,
    LO_QUARTER = 2'd2,
    LO_EIGHTH  = 2'd3
  } lo_sel_e;

  typedef enum logic [2:0] {
    K_ZERO = 3'd0,
    K_POS1 = 3'd1,
    K_NEG1 = 3'd2,
    K_POSR = 3'd3,
    K_NEGR = 3'd4
  } coef_e;

  typedef struct packed {
    lo_sel_e lo;
    logic    zstuff;
    logic    couple;
  } cfg_t;

  function automatic coef_e coef_neg(coef_e k);
    case (k)
      K_POS1:  return K_NEG1;
      K_NEG1:  return K_POS1;
      K_POSR:  return K_NEGR;
      K_NEGR:  return K_POSR;
      default: return K_ZERO;
    endcase
  endfunction

  function automatic coef_e cos_coef(lo_sel_e lo, logic [PH_W-1:0] ph);
    case (lo)
      LO_HALF:    return ph[0] ? K_NEG1 : K_POS1;
      LO_QUARTER: case (ph[1:0])
                    2'd0:    return K_POS1;
                    2'd2:    return K_NEG1;
                    default: return K_ZERO;
                  endcase
      LO_EIGHTH:  case (ph)
                    3'd0:        return K_POS1;
                    3'd1, 3'd7:  return K_POSR;
                    3'd3, 3'd5:  return K_NEGR;
                    3'd4:        return K_NEG1;
                    default:     return K_ZERO;
                  endcase
      default:    return K_POS1;
    endcase
  endfunction

  function automatic coef_e sin_coef(lo_sel_e lo, logic [PH_W-1:0] ph);
    case (lo)
      LO_QUARTER: case (ph[1:0])
                    2'd1:    return K_POS1;
                    2'd3:    return K_NEG1;
                    default: return K_ZERO;
                  endcase
      LO_EIGHTH:  case (ph)
                    3'd1, 3'd3:  return K_POSR;
                    3'd2:        return K_POS1;
                    3'd5, 3'd7:  return K_NEGR;
                    3'd6:        return K_NEG1;
                    default:     return K_ZERO;
                  endcase
      default:    return K_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/lo_mixer_stuff.sv
module lo_mixer_stuff #(
  parameter int unsigned DW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 zstuff_i,
  input  logic signed [DW-1:0] d_i,
  output logic signed [DW-1:0] s_o
);

  logic signed [DW-1:0] held_q, s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      s_q    <= '0;
    end else begin
      if (valid_i) begin
        held_q <= d_i;
        s_q    <= d_i;
      end else begin
        s_q <= zstuff_i ? '0 : held_q;
      end
    end
  end

  assign s_o = s_q;

  p_zero_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && zstuff_i) |=> (s_q == '0));

  p_take_sample_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (s_q == $past(d_i)));

  p_repeat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !zstuff_i && !$past(zstuff_i)) |=> $stable(s_q));

endmodule

// File: rtl/lo_mixer_phase.sv
module lo_mixer_phase
  import lo_mixer_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cfg_t            cfg_i,
  output logic [PH_W-1:0] ph_o,
  output cfg_t            cfg_o
);

  localparam cfg_t CFG_RST = '{lo: LO_NONE, zstuff: 1'b0, couple: 1'b0};

  cfg_t            cfg_q;
  logic [PH_W-1:0] cnt_q, ph_q, ph_use;
  logic            chg;

  assign chg    = (cfg_i != cfg_q);
  assign ph_use = chg ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      cnt_q <= '0;
      ph_q  <= '1;  // keeps cnt_q == ph_q + 1 from reset onward
    end else begin
      cfg_q <= cfg_i;
      cnt_q <= ph_use + 1'b1;
      ph_q  <= ph_use;
    end
  end

  assign ph_o  = ph_q;
  assign cfg_o = cfg_q;

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i != cfg_q) |=> (ph_q == '0));

  p_advance_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == cfg_q) |=> (ph_q == PH_W'($past(ph_q) + 1'b1)));

endmodule

// File: rtl/lo_mixer_core.sv
module lo_mixer_core
  import lo_mixer_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned CF    = 15,
  parameter int unsigned RCOEF = 23170
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  cfg_t                 cfg_i,
  input  logic [PH_W-1:0]      ph_i,
  input  logic signed [DW-1:0] sa_i,
  input  logic signed [DW-1:0] sb_i,
  output logic signed [DW-1:0] ya_o,
  output logic signed [DW-1:0] yb_o
);

  localparam int unsigned PROD_W = DW + CF + 1;
  localparam int unsigned TW     = DW + 1;
  localparam int unsigned SW     = DW + 2;
  localparam logic signed [CF:0]       R_S  = (CF+1)'(RCOEF);
  localparam logic signed [PROD_W-1:0] RND  = PROD_W'(1) <<< (CF - 1);
  localparam logic signed [SW-1:0]     SMAX = SW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [SW-1:0]     SMIN = -SMAX - SW'(1);
  localparam logic signed [DW-1:0]     DMIN = {1'b1, {(DW-1){1'b0}}};

  function automatic logic signed [TW-1:0] term(coef_e k, logic signed [DW-1:0] x);
    logic signed [PROD_W-1:0] p;
    logic signed [TW-1:0]     r, xe;
    p  = (PROD_W'(x) * PROD_W'(R_S)) + RND;
    r  = $signed(p[CF +: TW]);
    xe = $signed({x[DW-1], x});
    case (k)
      K_POS1:  return xe;
      K_NEG1:  return -xe;
      K_POSR:  return r;
      K_NEGR:  return -r;
      default: return '0;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] sat(logic signed [SW-1:0] v);
    if (v > SMAX)      return SMAX[DW-1:0];
    else if (v < SMIN) return SMIN[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  coef_e                kc, ks, ks_n;
  logic signed [TW-1:0] t_ac, t_bs, t_as, t_bc;
  logic signed [SW-1:0] sum_a, sum_b;
  logic signed [DW-1:0] ya_q, yb_q;

  always_comb begin
    kc    = cos_coef(cfg_i.lo, ph_i);
    ks    = sin_coef(cfg_i.lo, ph_i);
    ks_n  = coef_neg(ks);
    t_ac  = term(kc, sa_i);
    t_bc  = term(kc, sb_i);
    t_as  = cfg_i.couple ? term(ks, sa_i)   : '0;
    t_bs  = cfg_i.couple ? term(ks_n, sb_i) : '0;
    sum_a = SW'(t_ac) + SW'(t_bs);
    sum_b = cfg_i.couple ? (SW'(t_as) + SW'(t_bc)) : SW'(t_bc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ya_q <= '0;
      yb_q <= '0;
    end else begin
      ya_q <= sat(sum_a);
      yb_q <= sat(sum_b);
    end
  end

  assign ya_o = ya_q;
  assign yb_o = yb_q;

  p_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.lo == LO_NONE && !cfg_i.couple)
      |=> (ya_q == $past(sa_i) && yb_q == $past(sb_i)));

  p_half_flip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.lo == LO_HALF && !cfg_i.couple && ph_i[0] && sa_i != DMIN)
      |=> (ya_q == -$past(sa_i)));

  p_quarter_null_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.lo == LO_QUARTER && !cfg_i.couple && ph_i[0])
      |=> (ya_q == '0 && yb_q == '0));

endmodule

// File: rtl/lo_mixer.sv
module lo_mixer
  import lo_mixer_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned CF    = 15,
  parameter int unsigned RCOEF = 23170
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic [1:0]           lo_sel_i,
  input  logic                 zstuff_i,
  input  logic                 couple_i,
  output logic signed [DW-1:0] a_o,
  output logic signed [DW-1:0] b_o
);

  localparam int unsigned NCH = 2;

  cfg_t                 cfg_in, cfg_s1;
  logic [PH_W-1:0]      ph_s1;
  logic signed [DW-1:0] din [NCH];
  logic signed [DW-1:0] sval[NCH];

  assign cfg_in = '{lo: lo_sel_e'(lo_sel_i), zstuff: zstuff_i, couple: couple_i};
  assign din[0] = a_i;
  assign din[1] = b_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lo_mixer_stuff #(.DW(DW)) u_stuff (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_i),
      .zstuff_i (zstuff_i),
      .d_i      (din[c]),
      .s_o      (sval[c])
    );
  end

  lo_mixer_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_in),
    .ph_o   (ph_s1),
    .cfg_o  (cfg_s1)
  );

  lo_mixer_core #(.DW(DW), .CF(CF), .RCOEF(RCOEF)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_s1),
    .ph_i   (ph_s1),
    .sa_i   (sval[0]),
    .sb_i   (sval[1]),
    .ya_o   (a_o),
    .yb_o   (b_o)
  );

  p_reset_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (a_o == '0 && b_o == '0));

endmodule

// File: tb/lo_mixer_bench.sv
module lo_mixer_bench;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              valid_i;
  logic signed [11:0] a_i, b_i;
  logic [1:0]        lo_sel_i;
  logic              zstuff_i, couple_i;
  logic signed [11:0] a_o, b_o;

  always #10 clk = ~clk;

  lo_mixer u_lo_mixer (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .lo_sel_i(lo_sel_i), .zstuff_i(zstuff_i), .couple_i(couple_i),
    .a_o(a_o), .b_o(b_o)
  );

  typedef struct { int ea; int eb; string tag; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  bit run = 1'b0;
  int seed = 7;

  // scoreboard model state
  int cfg_lo = 0, cfg_zs = 0, cfg_cp = 0;
  int prv_lo = 0, prv_zs = 0, prv_cp = 0;
  int cnt = 0, held_a = 0, held_b = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rnd12();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 32'hFFF) - 2048;
  endfunction

  // coefficient codes: 0 zero, 1 +1, -1 -1, 2 +c, -2 -c
  function automatic int lo_cos(int lo, int ph);
    case (lo)
      0: return 1;
      1: return (ph % 2 == 0) ? 1 : -1;
      2: case (ph % 4) 0: return 1; 2: return -1; default: return 0; endcase
      default: case (ph) 0: return 1; 1: return 2; 2: return 0; 3: return -2;
                         4: return -1; 5: return -2; 6: return 0; default: return 2; endcase
    endcase
  endfunction

  function automatic int lo_sin(int lo, int ph);
    case (lo)
      2: case (ph % 4) 1: return 1; 3: return -1; default: return 0; endcase
      3: case (ph) 1: return 2; 2: return 1; 3: return 2; 5: return -2;
                   6: return -1; 7: return -2; default: return 0; endcase
      default: return 0;
    endcase
  endfunction

  function automatic int mterm(int k, int x);
    int r;
    r = (x * 23170 + 16384) >>> 15;
    case (k)
      1: return x;  -1: return -x;  2: return r;  -2: return -r;
      default: return 0;
    endcase
  endfunction

  function automatic int sat(int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic step(input bit v, input int a, input int b, input string tag);
    exp_t e;
    int ph, sa, sb, kc, ks;
    @(negedge clk);
    valid_i  = v;
    a_i      = 12'(a);
    b_i      = 12'(b);
    lo_sel_i = 2'(cfg_lo);
    zstuff_i = 1'(cfg_zs);
    couple_i = 1'(cfg_cp);
    ph = (cfg_lo != prv_lo || cfg_zs != prv_zs || cfg_cp != prv_cp) ? 0 : cnt;
    cnt = (ph + 1) % 8;
    prv_lo = cfg_lo; prv_zs = cfg_zs; prv_cp = cfg_cp;
    if (v) begin sa = a; sb = b; held_a = a; held_b = b; end
    else if (cfg_zs != 0) begin sa = 0; sb = 0; end
    else begin sa = held_a; sb = held_b; end
    kc = lo_cos(cfg_lo, ph);
    ks = lo_sin(cfg_lo, ph);
    if (cfg_cp != 0) begin
      e.ea = sat(mterm(kc, sa) - mterm(ks, sb));
      e.eb = sat(mterm(ks, sa) + mterm(kc, sb));
    end else begin
      e.ea = sat(mterm(kc, sa));
      e.eb = sat(mterm(kc, sb));
    end
    e.tag = $sformatf("%s ph%0d", tag, ph);
    q.push_back(e);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: output after edge k+1 belongs to input of edge k (R9)
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (run && q.size() >= 2) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " R9 A"}, int'(a_o), e.ea);
        chk({e.tag, " R9 B"}, int'(b_o), e.eb);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; a_i = '0; b_i = '0;
    lo_sel_i = '0; zstuff_i = 1'b0; couple_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #5;
    chk("R1 A after reset", int'(a_o), 0);
    chk("R1 B after reset", int'(b_o), 0);
    run = 1'b1;

    // R2 bypass, every cycle valid
    for (int i = 0; i < 8; i++) step(1, rnd12(), rnd12(), "R2");
    step(1, 2047, -2048, "R2");

    // R3 half rate, incl. -2048 on odd phase -> saturates
    cfg_lo = 1;
    for (int i = 0; i < 6; i++) step(1, rnd12(), rnd12(), "R3");
    step(1, 5, 5, "R3");
    step(1, -2048, -2048, "R3 sat");
    step(1, -2048, 2047, "R3 sat");

    // R4 quarter rate
    cfg_lo = 2;
    for (int i = 0; i < 8; i++) step(1, rnd12(), rnd12(), "R4");

    // R5 eighth rate, odd values exercise rounding
    cfg_lo = 3;
    for (int i = 0; i < 8; i++) step(1, 2047, -2048, "R5");
    for (int i = 0; i < 16; i++) step(1, rnd12(), rnd12(), "R5");
    for (int i = 0; i < 8; i++) step(1, -3 + i, 1 - i, "R5");

    // R10 independent channels, A constant, B varying
    cfg_lo = 2;
    for (int i = 0; i < 8; i++) step(1, 1000, rnd12(), "R10");

    // R6 zero-stuff vs hold, valid every other cycle
    cfg_lo = 0; cfg_zs = 1;
    for (int i = 0; i < 8; i++) step((i % 2) == 0, rnd12(), rnd12(), "R6 stuff");
    cfg_zs = 0;
    for (int i = 0; i < 8; i++) step((i % 2) == 0, rnd12(), rnd12(), "R6 hold");
    cfg_lo = 3; cfg_zs = 1;
    for (int i = 0; i < 8; i++) step((i % 2) == 0, rnd12(), rnd12(), "R6 mixed");

    // R7 coupled modes with full-scale inputs
    cfg_zs = 0; cfg_cp = 1;
    for (int i = 0; i < 8; i++) step(1, 2047, 2047, "R7 sat");
    for (int i = 0; i < 8; i++) step(1, -2048, 2047, "R7 sat");
    for (int i = 0; i < 16; i++) step(1, rnd12(), rnd12(), "R7");
    cfg_lo = 2;
    for (int i = 0; i < 8; i++) step(1, rnd12(), rnd12(), "R7");
    cfg_lo = 1;
    for (int i = 0; i < 4; i++) step(1, -2048, -2048, "R7");

    // R8 restarts coinciding with stuffed zero slots
    cfg_lo = 3; cfg_zs = 1; cfg_cp = 0;
    for (int i = 0; i < 5; i++) step((i % 2) == 0, 1500, -700, "R8");
    cfg_lo = 2;
    step(0, 0, 0, "R8 restart on zero");
    for (int i = 0; i < 5; i++) step((i % 2) == 0, -1200, 900, "R8");
    cfg_cp = 1;
    step(0, 0, 0, "R8 couple toggle");
    for (int i = 0; i < 6; i++) step((i % 2) == 0, 2047, 2047, "R8");
    cfg_lo = 3;
    for (int i = 0; i < 9; i++) step((i % 2) == 1, rnd12(), rnd12(), "R8");

    step(0, 0, 0, "drain");
    step(0, 0, 0, "drain");
    @(posedge clk); #6;
    summary();
    $finish;
  end

endmodule